// File: doc/BRIEF.md
# Byte-Coded Instruction Sequencer

This block is the fetch, decode and execute controller of a small 8-bit processor. It holds 256 bytes of RAM and eight 8-bit general registers. It reads one opcode byte and takes the operand count and the instruction class straight from fixed bit fields of that byte. It then fetches zero, one or two operand bytes and carries out the instruction: an arithmetic step through an external ALU, a jump or call, a load, store or stack move, a console print, or a halt. Arithmetic itself is done outside the block. The sequencer presents the operation code and the two register values, and it takes back a result, a three-bit compare flag set and two write enables.

A test or boot agent writes the program into RAM through a byte write port while the block is idle. A one-cycle `start` pulse begins execution at address 0. Print instructions emit one byte on `out_data` with a one-cycle `out_valid` strobe. `halted` rises when a halt instruction runs or when an illegal opcode is found. In the illegal case `error` rises as well.

The states are IDLE, FETCH, DECODE, OPA, OPB, EXEC, WBACK and STOP. The transitions are:
- IDLE to FETCH on `start`.
- FETCH to DECODE always.
- DECODE to EXEC when the count field is 0, to OPA when it is 1 or 2, and to STOP when it is 3.
- OPA to OPB when the count is 2, otherwise to EXEC.
- OPB to EXEC.
- EXEC to STOP on halt or an illegal code, to WBACK for LD, POP and RET, otherwise to FETCH.
- WBACK to FETCH.
- STOP holds until reset.

Top module: `bytecode_seq`

## Requirements
- R1: Opcode bits 7:6 give the operand count. A count of 3 sends the sequencer from DECODE to STOP with `error` high, and the instruction does nothing else.
- R2: An instruction with n operands takes FETCH, DECODE, n operand states, EXEC, and then WBACK for LD, POP or RET only. The next FETCH follows at once.
- R3: LDI (0x82, operands reg, immediate) writes the immediate. PRN (0x47) and PRA (0x48) put the named register on `out_data`, with `out_char` 0 for PRN and 1 for PRA, and raise `out_valid` for exactly one cycle, the cycle after EXEC.
- R4: Bit 5 set marks an ALU instruction. `alu_op` is bits 3:0, and `alu_a`/`alu_b` are registers A and B. `alu_y` is written to register A when `alu_we_reg` is high. `alu_flags` is written to the flag register when `alu_we_flags` is high. An ALU code that asserts neither write enable changes nothing.
- R5: The PC advances by 1 plus the operand count before execution. JMP (0x54) replaces it with the value of the named register.
- R6: The flag register holds equal in bit 0, greater in bit 1 and less in bit 2. The conditional jumps are 0x55 through 0x5A, in the order JEQ, JNE, JGT, JLT, JLE, JGE. JEQ tests E, JNE tests not E, JGT tests G, JLT tests L, JLE tests E or L, and JGE tests E or G.
- R7: The stack pointer resets to 0xF4. PUSH (0x45) decrements it and then writes the register. POP (0x46) reads from it into the register and then increments it.
- R8: CALL (0x50) pushes the address after its operand and jumps to the register value. RET (0x11) pops the PC.
- R9: LD (0x83, A, B) loads register A from RAM at the address in register B. ST (0x84, A, B) stores register B at the address in register A.
- R10: HLT (0x01) moves to STOP. `halted` stays high until reset, `error` stays low, and no further output appears.
- R11: An unrecognised code stops execution with `halted` and `error` high. In the non-ALU, non-branch class the codes 0 and 9–15 are unrecognised. In the branch class (bit 4) the codes 2, 3 and 11–15 are unrecognised.
- R12: After reset the block stays in IDLE, with all outputs low, until `start`. A `start` seen in STOP is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (IDLE only) |
| load_en | input | 1 | Program write strobe |
| load_addr | input | 8 | Program write address |
| load_data | input | 8 | Program write byte |
| alu_op | output | 4 | ALU operation code (opcode bits 3:0) |
| alu_a | output | 8 | Register A value |
| alu_b | output | 8 | Register B value |
| alu_go | output | 1 | High during EXEC of an ALU instruction |
| alu_y | input | 8 | ALU result |
| alu_flags | input | 3 | ALU compare flags {L,G,E} |
| alu_we_reg | input | 1 | ALU asks for result write |
| alu_we_flags | input | 1 | ALU asks for flag write |
| out_data | output | 8 | Printed byte |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| out_char | output | 1 | 1 for a character print, 0 for a numeric print |
| halted | output | 1 | Sequencer is in STOP |
| error | output | 1 | STOP was entered through an illegal opcode |

## Verification
A behavioural instruction-level model in the bench predicts the exact cycle of every print strobe and of the halt. The DUT is then compared with it on every clock. A wrong state count, for example a missing WBACK or an extra operand state, therefore shows up as a strobe in the wrong cycle. All six conditional jumps are run against equal, greater and less comparisons. A wrong flag test would print the skipped marker or drop it. CALL/RET, PUSH/POP and LD/ST check the return address and the stack order. Getting either wrong would print the wrong value or jump to the wrong place. Illegal codes in each class, a count field of 3, and a late `start` pulse check that the design stops with the right error and stays stopped.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_OPA,
        ST_OPB,
        ST_EXEC,
        ST_WBACK,
        ST_STOP
    } seq_state_e;

    // plain (non-ALU, non-branch) class codes
    localparam logic [3:0] OP_HLT  = 4'd1;
    localparam logic [3:0] OP_LDI  = 4'd2;
    localparam logic [3:0] OP_LD   = 4'd3;
    localparam logic [3:0] OP_ST   = 4'd4;
    localparam logic [3:0] OP_PUSH = 4'd5;
    localparam logic [3:0] OP_POP  = 4'd6;
    localparam logic [3:0] OP_PRN  = 4'd7;
    localparam logic [3:0] OP_PRA  = 4'd8;

    // branch class codes
    localparam logic [3:0] BR_CALL = 4'd0;
    localparam logic [3:0] BR_RET  = 4'd1;
    localparam logic [3:0] BR_JMP  = 4'd4;
    localparam logic [3:0] BR_JEQ  = 4'd5;
    localparam logic [3:0] BR_JNE  = 4'd6;
    localparam logic [3:0] BR_JGT  = 4'd7;
    localparam logic [3:0] BR_JLT  = 4'd8;
    localparam logic [3:0] BR_JLE  = 4'd9;
    localparam logic [3:0] BR_JGE  = 4'd10;

    // flag bit positions
    localparam int FL_EQ = 0;
    localparam int FL_GT = 1;
    localparam int FL_LT = 2;

endpackage

// File: rtl/seq_ram.sv
module seq_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int RIW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RIW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RIW-1:0] raddr_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [RIW-1:0] raddr_b,
    output logic [DW-1:0]  rdata_b
);
    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && waddr == RIW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/bytecode_seq.sv
module bytecode_seq
    import seq_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          NREG     = 8,
    parameter logic [7:0]  SP_RESET = 8'hF4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          load_en,
    input  logic [DW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic [3:0]    alu_op,
    output logic [DW-1:0] alu_a,
    output logic [DW-1:0] alu_b,
    output logic          alu_go,
    input  logic [DW-1:0] alu_y,
    input  logic [2:0]    alu_flags,
    input  logic          alu_we_reg,
    input  logic          alu_we_flags,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_char,
    output logic          halted,
    output logic          error
);
    localparam int RIW = $clog2(NREG);

    seq_state_e    state, nxt;
    logic [DW-1:0] pc, sp, ir, opa, opb;
    logic [2:0]    flags;

    // memory and register file connections
    logic          core_we;
    logic [DW-1:0] core_waddr, core_wdata, core_raddr, ram_q;
    logic          rf_we;
    logic [RIW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata, rd_a, rd_b;

    // opcode fields of the held instruction
    logic [1:0]    cnt;
    logic          is_alu, is_br;
    logic [3:0]    code;
    logic [DW-1:0] seq_pc;
    logic          legal, take, needs_wb, is_halt;

    assign cnt    = ir[7:6];
    assign is_alu = ir[5];
    assign is_br  = ir[4] & ~ir[5];
    assign code   = ir[3:0];
    assign seq_pc = pc + DW'(cnt) + DW'(1);

    seq_ram #(.AW(DW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (load_en | core_we),
        .waddr (load_en ? load_addr : core_waddr),
        .wdata (load_en ? load_data : core_wdata),
        .raddr (core_raddr),
        .rdata (ram_q)
    );

    seq_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (opa[RIW-1:0]),
        .rdata_a (rd_a),
        .raddr_b (opb[RIW-1:0]),
        .rdata_b (rd_b)
    );

    assign alu_op = code;
    assign alu_a  = rd_a;
    assign alu_b  = rd_b;
    assign halted = (state == ST_STOP);

    // instruction classification and branch decision
    always_comb begin
        legal    = 1'b1;
        take     = 1'b0;
        needs_wb = 1'b0;
        is_halt  = 1'b0;
        if (is_alu) begin
            legal = 1'b1;
        end else if (is_br) begin
            case (code)
                BR_CALL: take = 1'b1;
                BR_RET:  needs_wb = 1'b1;
                BR_JMP:  take = 1'b1;
                BR_JEQ:  take = flags[FL_EQ];
                BR_JNE:  take = ~flags[FL_EQ];
                BR_JGT:  take = flags[FL_GT];
                BR_JLT:  take = flags[FL_LT];
                BR_JLE:  take = flags[FL_EQ] | flags[FL_LT];
                BR_JGE:  take = flags[FL_EQ] | flags[FL_GT];
                default: legal = 1'b0;
            endcase
        end else begin
            case (code)
                OP_HLT:                                is_halt = 1'b1;
                OP_LDI, OP_ST, OP_PUSH, OP_PRN, OP_PRA: legal = 1'b1;
                OP_LD, OP_POP:                         needs_wb = 1'b1;
                default:                               legal = 1'b0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (ram_q[7:6] == 2'b11)      nxt = ST_STOP;
                else if (ram_q[7:6] == 2'b00) nxt = ST_EXEC;
                else                          nxt = ST_OPA;
            end
            ST_OPA:    nxt = (cnt == 2'd2) ? ST_OPB : ST_EXEC;
            ST_OPB:    nxt = ST_EXEC;
            ST_EXEC: begin
                if (!legal || is_halt) nxt = ST_STOP;
                else if (needs_wb)     nxt = ST_WBACK;
                else                   nxt = ST_FETCH;
            end
            ST_WBACK:  nxt = ST_FETCH;
            ST_STOP:   nxt = ST_STOP;
        endcase
    end

    // combinational controls per state
    always_comb begin
        core_raddr = pc;
        core_we    = 1'b0;
        core_waddr = sp - DW'(1);
        core_wdata = rd_a;
        rf_we      = 1'b0;
        rf_waddr   = opa[RIW-1:0];
        rf_wdata   = opb;
        alu_go     = 1'b0;
        unique case (state)
            ST_DECODE: core_raddr = pc + DW'(1);
            ST_OPA:    core_raddr = pc + DW'(2);
            ST_EXEC: begin
                if (is_alu) begin
                    alu_go   = 1'b1;
                    rf_we    = alu_we_reg;
                    rf_wdata = alu_y;
                end else if (is_br) begin
                    if (code == BR_CALL) begin
                        core_we    = 1'b1;
                        core_wdata = seq_pc;
                    end else if (code == BR_RET) begin
                        core_raddr = sp;
                    end
                end else begin
                    case (code)
                        OP_LDI:  rf_we = 1'b1;
                        OP_LD:   core_raddr = rd_b;
                        OP_ST: begin
                            core_we    = 1'b1;
                            core_waddr = rd_a;
                            core_wdata = rd_b;
                        end
                        OP_PUSH: core_we = 1'b1;
                        OP_POP:  core_raddr = sp;
                        default: ;
                    endcase
                end
            end
            ST_WBACK: begin
                if (!is_br) begin
                    rf_we    = 1'b1;
                    rf_wdata = ram_q;
                end
            end
            ST_IDLE, ST_FETCH, ST_OPB, ST_STOP: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            sp        <= SP_RESET;
            ir        <= '0;
            opa       <= '0;
            opb       <= '0;
            flags     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            out_char  <= 1'b0;
            error     <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                ST_DECODE: begin
                    ir <= ram_q;
                    if (ram_q[7:6] == 2'b11) error <= 1'b1;
                end
                ST_OPA: opa <= ram_q;
                ST_OPB: opb <= ram_q;
                ST_EXEC: begin
                    pc <= take ? rd_a : seq_pc;
                    if (!legal) error <= 1'b1;
                    if (is_alu && alu_we_flags) flags <= alu_flags;
                    if (is_br && code == BR_CALL) sp <= sp - DW'(1);
                    if (!is_alu && !is_br) begin
                        case (code)
                            OP_PUSH: sp <= sp - DW'(1);
                            OP_POP:  sp <= sp + DW'(1);
                            OP_PRN, OP_PRA: begin
                                out_valid <= 1'b1;
                                out_data  <= rd_a;
                                out_char  <= (code == OP_PRA);
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WBACK: begin
                    if (is_br) begin
                        pc <= ram_q;
                        sp <= sp + DW'(1);
                    end
                end
                ST_IDLE, ST_FETCH, ST_STOP: ;
            endcase
        end
    end
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input seq_state_e    state,
    input logic          out_valid,
    input logic          halted,
    input logic          error,
    input logic [DW-1:0] sp
);
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_quiet_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !out_valid);

    a_r11_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);

    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    a_r1_opb_after_opa: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPB) |-> ($past(state) == ST_OPA));

    a_r7_sp_moves_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> ($past(state) == ST_EXEC || $past(state) == ST_WBACK));

    a_r12_idle_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE));
endmodule

bind bytecode_seq seq_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .state     (state),
    .out_valid (out_valid),
    .halted    (halted),
    .error     (error),
    .sp        (sp)
);

// File: tb/tb_bytecode_seq.sv
module tb_bytecode_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_addr = '0, load_data = '0;
    logic [3:0] alu_op;
    logic [7:0] alu_a, alu_b, alu_y, out_data;
    logic       alu_go, alu_we_reg, alu_we_flags, out_valid, out_char, halted, error;
    logic [2:0] alu_flags;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bytecode_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_go(alu_go),
        .alu_y(alu_y), .alu_flags(alu_flags), .alu_we_reg(alu_we_reg), .alu_we_flags(alu_we_flags),
        .out_data(out_data), .out_valid(out_valid), .out_char(out_char),
        .halted(halted), .error(error)
    );

    // external ALU stand-in: returns {we_reg, we_flags, flags[2:0], y[7:0]}
    function automatic logic [12:0] alu_model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] y = '0; logic [2:0] f = '0; logic wr = 0, wf = 0;
        case (op)
            4'd0:  begin y = a + b;  wr = 1; end
            4'd1:  begin y = a - b;  wr = 1; end
            4'd2:  begin y = a * b;  wr = 1; end
            4'd5:  begin y = a + 1;  wr = 1; end
            4'd6:  begin y = a - 1;  wr = 1; end
            4'd7:  begin wf = 1; f = (a == b) ? 3'b001 : (a > b) ? 3'b010 : 3'b100; end
            4'd8:  begin y = a & b;  wr = 1; end
            4'd10: begin y = a | b;  wr = 1; end
            4'd11: begin y = a ^ b;  wr = 1; end
            4'd12: begin y = a << b[2:0]; wr = 1; end
            4'd13: begin y = a >> b[2:0]; wr = 1; end
            default: ;
        endcase
        return {wr, wf, f, y};
    endfunction

    always_comb {alu_we_reg, alu_we_flags, alu_flags, alu_y} = alu_model(alu_op, alu_a, alu_b);

    // program image and builder
    logic [7:0] img [256];
    int ptr;
    task automatic clear_img(); for (int i = 0; i < 256; i++) img[i] = 8'h00; ptr = 0; endtask
    task automatic put(input logic [7:0] v); img[ptr] = v; ptr++; endtask
    task automatic ldi(input logic [7:0] r, input logic [7:0] v); put(8'h82); put(r); put(v); endtask
    task automatic two(input logic [7:0] opc, input logic [7:0] x, input logic [7:0] y); put(opc); put(x); put(y); endtask
    task automatic one(input logic [7:0] opc, input logic [7:0] x); put(opc); put(x); endtask

    // behavioural reference: predicted output events and halt cycle
    int ev_edge[$]; logic [7:0] ev_data[$]; bit ev_kind[$];
    int halt_edge; bit exp_err;

    task automatic iss_run();
        logic [7:0] m [256]; logic [7:0] r [8];
        logic [7:0] pc, sp, op, a, bb, npc;
        logic [2:0] fl; logic [12:0] ar; logic [1:0] cnt; logic [3:0] c;
        int b, e, extra, steps; bit done, tk;
        for (int i = 0; i < 256; i++) m[i] = img[i];
        for (int i = 0; i < 8; i++) r[i] = 8'h00;
        pc = 0; sp = 8'hF4; fl = 0; b = 1; done = 0; steps = 0; exp_err = 0; halt_edge = 1000000;
        ev_edge.delete(); ev_data.delete(); ev_kind.delete();
        while (!done && steps < 3000) begin
            steps++;
            op = m[pc]; cnt = op[7:6]; c = op[3:0];
            if (cnt == 2'b11) begin
                exp_err = 1; halt_edge = b + 1; done = 1;
            end else begin
                a = m[8'(pc + 1)]; bb = m[8'(pc + 2)];
                e = b + 2 + int'(cnt); npc = 8'(pc + 1 + cnt); extra = 0;
                if (op[5]) begin
                    ar = alu_model(c, r[a[2:0]], r[bb[2:0]]);
                    if (ar[12]) r[a[2:0]] = ar[7:0];
                    if (ar[11]) fl = ar[10:8];
                end else if (op[4]) begin
                    tk = 0;
                    case (c)
                        0: begin sp = sp - 1; m[sp] = npc; npc = r[a[2:0]]; end
                        1: begin npc = m[sp]; sp = sp + 1; extra = 1; end
                        4: tk = 1;
                        5: tk = fl[0];
                        6: tk = !fl[0];
                        7: tk = fl[1];
                        8: tk = fl[2];
                        9: tk = fl[0] | fl[2];
                        10: tk = fl[0] | fl[1];
                        default: begin exp_err = 1; halt_edge = e; done = 1; end
                    endcase
                    if (tk) npc = r[a[2:0]];
                end else begin
                    case (c)
                        1: begin halt_edge = e; done = 1; end
                        2: r[a[2:0]] = bb;
                        3: begin r[a[2:0]] = m[r[bb[2:0]]]; extra = 1; end
                        4: m[r[a[2:0]]] = r[bb[2:0]];
                        5: begin sp = sp - 1; m[sp] = r[a[2:0]]; end
                        6: begin r[a[2:0]] = m[sp]; sp = sp + 1; extra = 1; end
                        7, 8: begin ev_edge.push_back(e); ev_data.push_back(r[a[2:0]]); ev_kind.push_back(c == 8); end
                        default: begin exp_err = 1; halt_edge = e; done = 1; end
                    endcase
                end
                pc = npc; b = e + 1 + extra;
            end
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (halted !== 0 || error !== 0 || out_valid !== 0) begin
            failures++;
            $display("FAIL %s idle: halt/err/valid actual=%0b/%0b/%0b expected=0/0/0", tag, halted, error, out_valid);
        end
    endtask

    task automatic run_prog(input string tag);
        int limit, ei; bit xv; logic [7:0] xd; bit xk;
        rst_n = 0; start = 0; load_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); load_en = 1; load_addr = 8'(i); load_data = img[i];
        end
        @(negedge clk); load_en = 0;
        repeat (3) @(negedge clk);
        check_idle({tag, " R12"});
        iss_run();
        limit = (halt_edge < 100000) ? halt_edge + 10 : 20000;
        start = 1;
        @(posedge clk);
        ei = 0;
        for (int n = 0; n <= limit; n++) begin
            @(negedge clk);
            xv = (ei < ev_edge.size()) && (ev_edge[ei] == n);
            xd = xv ? ev_data[ei] : 8'h00;
            xk = xv ? ev_kind[ei] : 1'b0;
            checks++;
            if (out_valid !== xv || (xv && (out_data !== xd || out_char !== xk)) ||
                halted !== (n >= halt_edge) || error !== (exp_err && n >= halt_edge)) begin
                failures++;
                $display("FAIL %s cycle %0d: valid/data/char/halt/err actual=%0b/%02h/%0b/%0b/%0b expected=%0b/%02h/%0b/%0b/%0b",
                         tag, n, out_valid, out_data, out_char, halted, error,
                         xv, xd, xk, (n >= halt_edge), (exp_err && n >= halt_edge));
            end
            if (xv) ei++;
            start = (n == halt_edge + 3);  // R12: late start must be ignored
            @(posedge clk);
        end
        @(negedge clk); start = 0;
        checks++;
        if (ei != ev_edge.size()) begin
            failures++;
            $display("FAIL %s outputs seen actual=%0d expected=%0d", tag, ei, ev_edge.size());
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R12 reset");
        rst_n = 1;
        repeat (4) @(negedge clk);
        check_idle("R12 no start");

        // R3: immediate load and both print kinds
        clear_img(); ldi(0, 8'h41); one(8'h47, 0); one(8'h48, 0); ldi(5, 8'hFF); one(8'h47, 5); put(8'h01);
        run_prog("R3");

        // R4: ALU ops, flag-only compare, unknown ALU code writes nothing
        clear_img(); ldi(0, 7); ldi(1, 5);
        two(8'hA0, 0, 1); one(8'h47, 0); two(8'hA1, 0, 1); one(8'h47, 0);
        two(8'hA2, 0, 1); one(8'h47, 0); one(8'h65, 1); one(8'h47, 1);
        ldi(2, 3); two(8'hAC, 2, 1); one(8'h47, 2); two(8'hAB, 0, 2); one(8'h47, 0);
        two(8'hA7, 0, 1); one(8'h47, 0); two(8'hAF, 0, 1); one(8'h47, 0); put(8'h01);
        run_prog("R4");

        // R5: unconditional jump skips a print
        clear_img(); ldi(3, 8'h33); ldi(4, 8'h44); ldi(2, 13); one(8'h54, 2); one(8'h47, 3);
        one(8'h47, 4); put(8'h01);
        run_prog("R5");

        // R6: six conditional jumps against equal, greater, less
        clear_img(); ldi(3, 8'h11); ldi(4, 8'h22);
        for (int p = 0; p < 3; p++) begin
            ldi(0, (p == 0) ? 8'd5 : (p == 1) ? 8'd9 : 8'd2);
            ldi(1, (p == 0) ? 8'd5 : (p == 1) ? 8'd3 : 8'd8);
            two(8'hA7, 0, 1);
            for (int j = 5; j <= 10; j++) begin
                ldi(2, 8'(ptr + 7)); one(8'h50 | 8'(j), 2); one(8'h47, 3); one(8'h47, 4);
            end
        end
        put(8'h01);
        run_prog("R6");

        // R7: stack order and stack pointer start
        clear_img(); ldi(0, 8'h5A); ldi(1, 8'hA5); one(8'h45, 0); one(8'h45, 1);
        one(8'h46, 2); one(8'h46, 3); one(8'h47, 2); one(8'h47, 3);
        ldi(6, 8'hF3); two(8'h83, 5, 6); one(8'h47, 5); put(8'h01);
        run_prog("R7");

        // R8: call pushes return address, ret comes back
        clear_img(); ldi(3, 8'h77); ldi(1, 11); one(8'h50, 1); one(8'h47, 3); put(8'h01);
        ldi(3, 8'h66); ldi(6, 8'hF3); two(8'h83, 5, 6); one(8'h47, 5); put(8'h11);
        run_prog("R8");

        // R9: store then load, and load from program bytes
        clear_img(); ldi(0, 8'hC0); ldi(1, 8'h3C); two(8'h84, 0, 1); ldi(2, 0);
        two(8'h83, 2, 0); one(8'h48, 2); ldi(6, 0); two(8'h83, 7, 6); one(8'h47, 7); put(8'h01);
        run_prog("R9");

        // R2: counted loop mixing zero, one and two operand instructions
        clear_img(); ldi(0, 3); ldi(1, 0); one(8'h47, 0); one(8'h66, 0); two(8'hA7, 0, 1);
        ldi(2, 6); one(8'h56, 2); put(8'h01);
        run_prog("R2");

        // R10: halt stops before a following print
        clear_img(); ldi(0, 1); one(8'h47, 0); put(8'h01); one(8'h47, 0);
        run_prog("R10");

        // R11: unrecognised codes in each class
        clear_img(); ldi(0, 9); one(8'h47, 0); put(8'h09); one(8'h47, 0);
        run_prog("R11 plain 9");
        clear_img(); ldi(0, 2); one(8'h47, 0); put(8'h12); one(8'h47, 0);
        run_prog("R11 branch 2");
        clear_img(); put(8'h00); one(8'h47, 0);
        run_prog("R11 plain 0");

        // R1: operand count field of 3
        clear_img(); ldi(0, 4); one(8'h47, 0); put(8'hC1); one(8'h47, 0);
        run_prog("R1");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule